// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller with Selectable Write Policies

This block sits between a processor load/store port and a slower main-memory port that moves whole lines in bursts. It keeps one tag, one valid bit and one dirty bit per line, together with a word-organised line store. A load that finds its line present is answered from the store without touching memory. A load that misses fetches the whole line as a burst of consecutive words, installs it, checks the tag again and then answers.

Two build-time parameters set the store behaviour. `WRITE_BACK` chooses whether a store hit only updates the line and marks it dirty, or also sends the same bytes to memory at once. `WRITE_ALLOC` chooses whether a store miss first brings the line in, or goes straight to memory and leaves the cache alone. A store carries a byte-enable mask over one 64-bit word. No line data changes until the tag compare has confirmed a hit. A line that is replaced goes back to memory only when its dirty bit is set.

The processor side uses a valid/ready request and a one-cycle done strobe. The memory side uses a request/acknowledge handshake followed by one beat-valid pulse per word.

Top module: `dcache_ctl`

## Requirements
- R1: After reset every line is invalid, `cpuReady` is 1, and both `cpuDone` and `memReq` are 0. The first access to any address is therefore a miss.
- R2: A load hit issues no memory request. `cpuDone` is high, with the addressed word on `cpuRdata`, in the second cycle after the accepting edge.
- R3: A load miss on a clean line raises `memReq` with `memWe`=0, `memBurst`=1 and the line-aligned address. It takes exactly LINE_BYTES/WORD_BYTES beats, marks the line valid and clean, and returns the word. With a memory that acknowledges one cycle after the request and then sends one beat per cycle, done arrives in cycle BEATS+5.
- R4: Bit i of `cpuBe` enables byte i (bits 8i+7..8i) of the 64-bit word. Only enabled bytes change, and only after a tag-check cycle has found a hit.
- R5: With WRITE_BACK=0, a store hit updates the line and issues one single-word memory write (`memBurst`=0) with the same byte enables. Done arrives in cycle 5, and lines never become dirty.
- R6: With WRITE_BACK=1, a store hit updates only the line, sets its dirty bit and issues no memory write. Done arrives in cycle 2.
- R7: A miss on a dirty line first writes the whole victim line to memory as a burst at the victim's own address, then refills. A load done arrives in cycle 2·BEATS+7.
- R8: A miss on a clean victim discards it with no memory write.
- R9: With WRITE_ALLOC=1, a store miss refills the line and then applies the store-hit action to it.
- R10: With WRITE_ALLOC=0, a store miss issues one single-word memory write and leaves the cache unchanged, so a later load of that address misses. Done arrives in cycle 5.
- R11: `cpuReady` is 0 whenever the controller is tag-checking, evicting, refilling or writing memory. A raised `memReq` stays high until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request valid |
| cpuReady | output | 1 | Controller can take a request this cycle |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 8·WORD_BYTES | Store data |
| cpuBe | input | WORD_BYTES | Store byte enables |
| cpuDone | output | 1 | Access complete (one cycle) |
| cpuRdata | output | 8·WORD_BYTES | Load data, valid with cpuDone |
| memReq | output | 1 | Memory transaction request |
| memAck | input | 1 | Memory accepted the request |
| memWe | output | 1 | Transaction is a write |
| memBurst | output | 1 | 1 = whole line, 0 = single word |
| memAddr | output | ADDR_W | Line-aligned or word-aligned address |
| memWdata | output | 8·WORD_BYTES | Write data for the current beat |
| memBe | output | WORD_BYTES | Byte enables for the current beat |
| memBeatValid | input | 1 | One beat transferred this cycle |
| memRdata | input | 8·WORD_BYTES | Read data for the current beat |

## Verification
Every latency is counted in cycles from the edge that accepts the request, against a memory model that acknowledges one cycle after a request and then sends one beat per cycle. With four-beat lines, a hit is due in cycle 2, a write-through or no-allocate store in cycle 5, a clean miss in cycle 9 and a dirty miss in cycle 15. The bench drives at falling edges and samples `cpuDone`, `cpuReady` and `cpuRdata` only at falling edges. It compares the measured cycle count with these figures, and at each done cycle it compares the backing memory and the model's write-transaction count with a byte-merged reference. Two instances cover the write-back/allocate and write-through/no-allocate builds, and sweeps cover every line, every word and every single-byte lane.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG_CHECK,
    ST_WRITEBACK,
    ST_REFILL,
    ST_WRITE_MEM,
    ST_RESPOND
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture a new processor request
    logic mergeStore;   // merge store bytes into the addressed word
    logic markDirty;    // set dirty bit of the addressed line
    logic refillBeat;   // write one refill beat into the line store
    logic finishRefill; // install tag, set valid, clear dirty
    logic selVictim;    // memory address from the stored tag
    logic selSingle;    // single-word memory write of the request
  } dpCtl_t;

endpackage

// File: rtl/dcache_datapath.sv
module dcache_datapath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 8,
  parameter int WRITE_BACK = 1,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int BEATS  = LINE_BYTES / WORD_BYTES,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BEAT_W-1:0] beatIdx,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [WORD_BYTES-1:0] cpuBe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              reqWe,
  output logic              lineHit,
  output logic              lineDirty,
  output logic [WORD_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_BYTES-1:0] memBe
);

  localparam int WOFF_W = $clog2(WORD_BYTES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int SLOTS  = NUM_LINES * BEATS;

  logic [ADDR_W-1:0]     reqAddr;
  logic [WORD_W-1:0]     reqWdata;
  logic [WORD_BYTES-1:0] reqBe;

  logic [TAG_W-1:0]  tagArr   [NUM_LINES];
  logic [NUM_LINES-1:0] validBits;
  logic [NUM_LINES-1:0] dirtyBits;
  logic [WORD_W-1:0] lineData [SLOTS];

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [BEAT_W-1:0] reqWord;
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] mergedWord;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqWord = reqAddr[WOFF_W +: BEAT_W];
  assign oldWord = lineData[{reqIdx, reqWord}];

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqBe    <= '0;
      reqWe    <= 1'b0;
    end else if (ctl.latchReq) begin
      reqAddr  <= cpuAddr;
      reqWdata <= cpuWdata;
      reqBe    <= cpuBe;
      reqWe    <= cpuWe;
    end
  end

  // byte-lane merge
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign mergedWord[b*8 +: 8] = reqBe[b] ? reqWdata[b*8 +: 8] : oldWord[b*8 +: 8];
  end

  // line store
  always_ff @(posedge clk) begin
    if (ctl.refillBeat) begin
      lineData[{reqIdx, beatIdx}] <= memRdata;
    end else if (ctl.mergeStore) begin
      lineData[{reqIdx, reqWord}] <= mergedWord;
    end
  end

  // tag array
  always_ff @(posedge clk) begin
    if (ctl.finishRefill) begin
      tagArr[reqIdx] <= reqTag;
    end
  end

  // status bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
      dirtyBits <= '0;
    end else if (ctl.finishRefill) begin
      validBits[reqIdx] <= 1'b1;
      dirtyBits[reqIdx] <= 1'b0;
    end else if (ctl.markDirty) begin
      dirtyBits[reqIdx] <= 1'b1;
    end
  end

  assign lineHit   = validBits[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign lineDirty = validBits[reqIdx] && dirtyBits[reqIdx];
  assign cpuRdata  = oldWord;

  // memory-side address and data
  always_comb begin
    if (ctl.selSingle) begin
      memAddr  = {reqAddr[ADDR_W-1:WOFF_W], {WOFF_W{1'b0}}};
      memWdata = reqWdata;
      memBe    = reqBe;
    end else begin
      memAddr  = ctl.selVictim ? {tagArr[reqIdx], reqIdx, {OFF_W{1'b0}}}
                               : {reqTag, reqIdx, {OFF_W{1'b0}}};
      memWdata = lineData[{reqIdx, beatIdx}];
      memBe    = '1;
    end
  end

  // R3
  refill_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.finishRefill |=> lineHit);

  // R5
  wt_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK == 0) |-> (dirtyBits == '0));

endmodule

// File: rtl/dcache_control.sv
module dcache_control
  import dcache_pkg::*;
#(
  parameter int BEATS       = 4,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              reqWe,
  input  logic              lineHit,
  input  logic              lineDirty,
  input  logic              memAck,
  input  logic              memBeatValid,
  output dpCtl_t            ctl,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              cpuReady,
  output logic              cpuDone,
  output logic              memReq,
  output logic              memWe,
  output logic              memBurst
);

  ctlState_e state, nextState;
  logic [BEAT_W-1:0] beatCnt;
  logic ackSeen;
  logic lastBeat;
  logic memPhase;

  assign lastBeat = (beatCnt == BEAT_W'(BEATS - 1));
  assign memPhase = (state == ST_WRITEBACK) || (state == ST_REFILL) || (state == ST_WRITE_MEM);

  always_comb begin
    nextState = state;
    ctl = '0;
    ctl.selVictim = (state == ST_WRITEBACK);
    ctl.selSingle = (state == ST_WRITE_MEM);
    case (state)
      ST_IDLE, ST_RESPOND: begin
        if (cpuValid) begin
          ctl.latchReq = 1'b1;
          nextState = ST_TAG_CHECK;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_TAG_CHECK: begin
        if (lineHit) begin
          if (reqWe) begin
            ctl.mergeStore = 1'b1;
            if (WRITE_BACK != 0) begin
              ctl.markDirty = 1'b1;
              nextState = ST_RESPOND;
            end else begin
              nextState = ST_WRITE_MEM;
            end
          end else begin
            nextState = ST_RESPOND;
          end
        end else if (reqWe && (WRITE_ALLOC == 0)) begin
          nextState = ST_WRITE_MEM;
        end else if (lineDirty) begin
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_REFILL;
        end
      end
      ST_WRITEBACK: begin
        if (memBeatValid && lastBeat) nextState = ST_REFILL;
      end
      ST_REFILL: begin
        ctl.refillBeat = memBeatValid;
        if (memBeatValid && lastBeat) begin
          ctl.finishRefill = 1'b1;
          nextState = ST_TAG_CHECK;
        end
      end
      ST_WRITE_MEM: begin
        if (memBeatValid) nextState = ST_RESPOND;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      ackSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        beatCnt <= '0;
        ackSeen <= 1'b0;
      end else begin
        if (memPhase && memBeatValid) beatCnt <= beatCnt + 1'b1;
        if (memAck) ackSeen <= 1'b1;
      end
    end
  end

  assign beatIdx  = beatCnt;
  assign cpuReady = (state == ST_IDLE) || (state == ST_RESPOND);
  assign cpuDone  = (state == ST_RESPOND);
  assign memReq   = memPhase && !ackSeen;
  assign memWe    = (state == ST_WRITEBACK) || (state == ST_WRITE_MEM);
  assign memBurst = (state == ST_WRITEBACK) || (state == ST_REFILL);

  // R11
  mem_busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);

  // R5
  wt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((WRITE_BACK == 0) && memReq && memWe) |-> !memBurst);

  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> !memReq);

endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl
  import dcache_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int WORD_BYTES  = 8,
  parameter int LINE_BYTES  = 32,
  parameter int NUM_LINES   = 8,
  parameter int WRITE_BACK  = 1,
  parameter int WRITE_ALLOC = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuValid,
  output logic                    cpuReady,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [WORD_BYTES*8-1:0] cpuWdata,
  input  logic [WORD_BYTES-1:0]   cpuBe,
  output logic                    cpuDone,
  output logic [WORD_BYTES*8-1:0] cpuRdata,
  output logic                    memReq,
  input  logic                    memAck,
  output logic                    memWe,
  output logic                    memBurst,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_BYTES*8-1:0] memWdata,
  output logic [WORD_BYTES-1:0]   memBe,
  input  logic                    memBeatValid,
  input  logic [WORD_BYTES*8-1:0] memRdata
);

  localparam int BEATS  = LINE_BYTES / WORD_BYTES;
  localparam int BEAT_W = $clog2(BEATS);

  dpCtl_t ctl;
  logic [BEAT_W-1:0] beatIdx;
  logic reqWe, lineHit, lineDirty;

  dcache_control #(
    .BEATS(BEATS), .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .reqWe(reqWe),
    .lineHit(lineHit), .lineDirty(lineDirty), .memAck(memAck),
    .memBeatValid(memBeatValid), .ctl(ctl), .beatIdx(beatIdx),
    .cpuReady(cpuReady), .cpuDone(cpuDone), .memReq(memReq),
    .memWe(memWe), .memBurst(memBurst)
  );

  dcache_datapath #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .WRITE_BACK(WRITE_BACK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .beatIdx(beatIdx), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuBe(cpuBe),
    .memRdata(memRdata), .reqWe(reqWe), .lineHit(lineHit),
    .lineDirty(lineDirty), .cpuRdata(cpuRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe)
  );

endmodule

// File: tb/dcache_ctl_test.sv
`timescale 1ns/100ps

module mem_model #(
  parameter int ADDR_W     = 12,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              memWe,
  input  logic              memBurst,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [63:0]       memWdata,
  input  logic [7:0]        memBe,
  output logic              memAck,
  output logic              memBeatValid,
  output logic [63:0]       memRdata
);
  localparam int DEPTH = (1 << ADDR_W) / WORD_BYTES;
  localparam int BEATS = LINE_BYTES / WORD_BYTES;

  logic [63:0] mem [DEPTH];
  int phase, cnt, base, writeCount;
  logic weQ, burstQ, lastBurst;
  logic [7:0] beQ, lastBe;
  logic [ADDR_W-1:0] lastAddr;

  function automatic logic [63:0] pat(int i);
    return {32'(i) * 32'h9E3779B1, ~32'(i)};
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= 0; cnt <= 0; base <= 0; writeCount <= 0;
      weQ <= 0; burstQ <= 0; beQ <= 0;
      lastBurst <= 0; lastBe <= 0; lastAddr <= 0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
    end else begin
      case (phase)
        0: if (memReq) begin
          phase <= 1;
          base <= int'(memAddr) / WORD_BYTES;
          weQ <= memWe; burstQ <= memBurst; beQ <= memBe;
          lastAddr <= memAddr; lastBe <= memBe; lastBurst <= memBurst;
          if (memWe) writeCount <= writeCount + 1;
        end
        1: begin phase <= 2; cnt <= 0; end
        default: begin
          if (weQ) begin
            for (int b = 0; b < 8; b++)
              if (beQ[b]) mem[base + cnt][b*8 +: 8] <= memWdata[b*8 +: 8];
          end
          cnt <= cnt + 1;
          if (cnt == (burstQ ? BEATS - 1 : 0)) phase <= 0;
        end
      endcase
    end
  end

  assign memAck       = (phase == 1);
  assign memBeatValid = (phase == 2);
  assign memRdata     = mem[(base + cnt) % DEPTH];
endmodule

module dcache_ctl_test;
  localparam int AW = 12;
  localparam int DEPTH = 512;

  logic clk = 0;
  logic rstN = 0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // instance A: write-back, write-allocate
  logic aValid = 0, aWe = 0, aReady, aDone;
  logic [AW-1:0] aAddr = 0;
  logic [63:0] aWdata = 0, aRdata;
  logic [7:0] aBe = 0;
  logic aMemReq, aMemAck, aMemWe, aMemBurst, aMemBeat;
  logic [AW-1:0] aMemAddr;
  logic [63:0] aMemWdata, aMemRdata;
  logic [7:0] aMemBe;

  // instance B: write-through, no-write-allocate
  logic bValid = 0, bWe = 0, bReady, bDone;
  logic [AW-1:0] bAddr = 0;
  logic [63:0] bWdata = 0, bRdata;
  logic [7:0] bBe = 0;
  logic bMemReq, bMemAck, bMemWe, bMemBurst, bMemBeat;
  logic [AW-1:0] bMemAddr;
  logic [63:0] bMemWdata, bMemRdata;
  logic [7:0] bMemBe;

  dcache_ctl #(.ADDR_W(AW), .WRITE_BACK(1), .WRITE_ALLOC(1)) uut (
    .clk(clk), .rstN(rstN), .cpuValid(aValid), .cpuReady(aReady), .cpuWe(aWe),
    .cpuAddr(aAddr), .cpuWdata(aWdata), .cpuBe(aBe), .cpuDone(aDone),
    .cpuRdata(aRdata), .memReq(aMemReq), .memAck(aMemAck), .memWe(aMemWe),
    .memBurst(aMemBurst), .memAddr(aMemAddr), .memWdata(aMemWdata),
    .memBe(aMemBe), .memBeatValid(aMemBeat), .memRdata(aMemRdata));

  mem_model #(.ADDR_W(AW)) mdlA (
    .clk(clk), .rstN(rstN), .memReq(aMemReq), .memWe(aMemWe),
    .memBurst(aMemBurst), .memAddr(aMemAddr), .memWdata(aMemWdata),
    .memBe(aMemBe), .memAck(aMemAck), .memBeatValid(aMemBeat),
    .memRdata(aMemRdata));

  dcache_ctl #(.ADDR_W(AW), .WRITE_BACK(0), .WRITE_ALLOC(0)) uutWt (
    .clk(clk), .rstN(rstN), .cpuValid(bValid), .cpuReady(bReady), .cpuWe(bWe),
    .cpuAddr(bAddr), .cpuWdata(bWdata), .cpuBe(bBe), .cpuDone(bDone),
    .cpuRdata(bRdata), .memReq(bMemReq), .memAck(bMemAck), .memWe(bMemWe),
    .memBurst(bMemBurst), .memAddr(bMemAddr), .memWdata(bMemWdata),
    .memBe(bMemBe), .memBeatValid(bMemBeat), .memRdata(bMemRdata));

  mem_model #(.ADDR_W(AW)) mdlB (
    .clk(clk), .rstN(rstN), .memReq(bMemReq), .memWe(bMemWe),
    .memBurst(bMemBurst), .memAddr(bMemAddr), .memWdata(bMemWdata),
    .memBe(bMemBe), .memAck(bMemAck), .memBeatValid(bMemBeat),
    .memRdata(bMemRdata));

  logic [63:0] refA [DEPTH];
  logic [63:0] refB [DEPTH];

  function automatic logic [63:0] seed(int i);
    return {32'(i) * 32'h9E3779B1, ~32'(i)};
  endfunction

  function automatic logic [63:0] mergeBytes(logic [63:0] oldW, logic [63:0] newW, logic [7:0] be);
    logic [63:0] r = oldW;
    for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = newW[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one processor access; latency counted in cycles after the accepting edge
  task automatic access(input bit wt, input bit we, input logic [AW-1:0] addr,
                        input logic [63:0] wdata, input logic [7:0] be,
                        output logic [63:0] rdata, output int lat, output bit readyOk);
    bit rdy;
    @(negedge clk);
    if (wt) begin bValid = 1; bWe = we; bAddr = addr; bWdata = wdata; bBe = be; end
    else    begin aValid = 1; aWe = we; aAddr = addr; aWdata = wdata; aBe = be; end
    forever begin
      rdy = wt ? bReady : aReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    aValid = 0; bValid = 0;
    lat = 1;
    readyOk = 1;
    forever begin
      if (wt ? bDone : aDone) break;
      if (wt ? bReady : aReady) readyOk = 0;
      if (lat > 300) break;
      @(negedge clk);
      lat++;
    end
    rdata = wt ? bRdata : aRdata;
  endtask

  task automatic run(input bit wt, input bit we, input logic [AW-1:0] addr,
                     input logic [63:0] wdata, input logic [7:0] be,
                     input int expLat, input string req);
    logic [63:0] rd;
    int lat;
    bit rok;
    int w = int'(addr) / 8;
    access(wt, we, addr, wdata, be, rd, lat, rok);
    check(lat == expLat, req, "done cycle", lat, expLat);
    check(rok, "R11", "cpuReady low while busy", 0, 0);
    if (we) begin
      if (wt) refB[w] = mergeBytes(refB[w], wdata, be);
      else    refA[w] = mergeBytes(refA[w], wdata, be);
    end else begin
      logic [63:0] exp = wt ? refB[w] : refA[w];
      check(rd == exp, req, "load data", rd, exp);
    end
  endtask

  initial begin
    int wc;
    for (int i = 0; i < DEPTH; i++) begin refA[i] = seed(i); refB[i] = seed(i); end
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(aReady == 1, "R1", "A ready after reset", aReady, 1);
    check(aDone == 0, "R1", "A done after reset", aDone, 0);
    check(aMemReq == 0, "R1", "A memReq after reset", aMemReq, 0);
    check(bReady == 1 && bDone == 0 && bMemReq == 0, "R1", "B idle after reset", bReady, 1);

    // R1 R3 R2: sweep every line, every word
    for (int l = 0; l < 8; l++) begin
      run(0, 0, AW'(l * 32), 0, 0, 9, "R3");
      check(mdlA.lastAddr == AW'(l * 32) && mdlA.lastBurst == 1, "R3",
            "refill address", mdlA.lastAddr, l * 32);
      for (int w = 0; w < 4; w++) run(0, 0, AW'(l * 32 + w * 8), 0, 0, 2, "R2");
    end
    check(mdlA.writeCount == 0, "R3", "no write on clean refill", mdlA.writeCount, 0);

    // R4 R6: each byte lane, then wider masks
    for (int b = 0; b < 8; b++) begin
      run(0, 1, 12'd8, 64'h1122334455667788 + 64'(b) * 64'h0101010101010101,
          8'(1 << b), 2, "R6");
      run(0, 0, 12'd8, 0, 0, 2, "R4");
    end
    run(0, 1, 12'd8, 64'hDEADBEEFCAFEF00D, 8'hF0, 2, "R6");
    run(0, 0, 12'd8, 0, 0, 2, "R4");
    run(0, 1, 12'd112, 64'h0F0E0D0C0B0A0908, 8'h0F, 2, "R6");
    run(0, 0, 12'd112, 0, 0, 2, "R4");
    check(mdlA.writeCount == 0, "R6", "write-back hits stay in cache", mdlA.writeCount, 0);
    check(mdlA.mem[1] == seed(1), "R6", "memory untouched by hit", mdlA.mem[1], seed(1));

    // R7 dirty eviction of line 0
    run(0, 0, 12'd256, 0, 0, 15, "R7");
    check(mdlA.writeCount == 1, "R7", "one burst write", mdlA.writeCount, 1);
    for (int w = 0; w < 4; w++)
      check(mdlA.mem[w] == refA[w], "R7", "victim word in memory", mdlA.mem[w], refA[w]);

    // R8 clean eviction of line 5
    run(0, 0, 12'd416, 0, 0, 9, "R8");
    check(mdlA.writeCount == 1, "R8", "clean victim not written", mdlA.writeCount, 1);

    // R9 write-allocate on clean line 6
    run(0, 1, 12'd464, 64'hA5A55A5A00FF7E81, 8'h3C, 9, "R9");
    check(mdlA.writeCount == 1, "R9", "allocate miss writes nothing", mdlA.writeCount, 1);
    run(0, 0, 12'd464, 0, 0, 2, "R9");
    run(0, 0, 12'd608, 0, 0, 15, "R7");
    check(mdlA.mem[14] == refA[14], "R7", "line 3 written back", mdlA.mem[14], refA[14]);
    run(0, 0, 12'd704, 0, 0, 15, "R9");
    check(mdlA.mem[58] == refA[58], "R9", "allocated store reached memory", mdlA.mem[58], refA[58]);
    check(mdlA.writeCount == 3, "R7", "burst write count", mdlA.writeCount, 3);

    // R5 write-through hit
    run(1, 0, 12'd0, 0, 0, 9, "R3");
    run(1, 0, 12'd8, 0, 0, 2, "R2");
    run(1, 1, 12'd8, 64'h0123456789ABCDEF, 8'h81, 5, "R5");
    check(mdlB.mem[1] == refB[1], "R5", "memory updated at once", mdlB.mem[1], refB[1]);
    check(mdlB.lastBurst == 0 && mdlB.lastBe == 8'h81, "R5", "single write enables",
          mdlB.lastBe, 8'h81);
    check(mdlB.writeCount == 1, "R5", "one memory write", mdlB.writeCount, 1);
    run(1, 0, 12'd8, 0, 0, 2, "R5");

    // R10 no-write-allocate
    run(1, 1, 12'd1064, 64'hFEDCBA9876543210, 8'hFF, 5, "R10");
    check(mdlB.mem[133] == refB[133], "R10", "store went to memory", mdlB.mem[133], refB[133]);
    run(1, 0, 12'd1064, 0, 0, 9, "R10");

    // R5 R8: written line stays clean in write-through
    wc = mdlB.writeCount;
    run(1, 0, 12'd256, 0, 0, 9, "R8");
    check(mdlB.writeCount == wc, "R5", "no eviction write", mdlB.writeCount, wc);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule